// File: doc/BRIEF.md
# PWM Time Base Counter

This block produces the 15-bit counter and the counting-direction flag that a set of PWM compare channels share. Its count clock is the system clock gated by a selectable prescaler. The counter can run freely, run for a single period and stop, or count up and down to form centre-aligned waveforms. The period comes from a double-buffered register. New period values are taken into use only at a safe point in the count, and that point depends on the counting mode. A 4-bit postscaler divides the period-match events into a one-cycle event pulse.

Software writes through three strobes that share one data bus: one strobe writes the counter, one writes the control word, and one writes the period buffer. The control word holds the enable bit, the counting mode, the prescale select and the postscale divide. A control write or a counter write restarts both the prescaler and the postscaler. A control write leaves the counter value as it is.

Top module: `pwm_timebase`

## Requirements
- R1: The prescale select field (control bits [3:2]) sets the count clock: 0 advances on every cycle, 1 on every 4th, 2 on every 16th, and 3 on every 64th. The first advance comes that many cycles after the enabling control write.
- R2: In a cycle with a counter write or a control write, the counter does not advance. The prescaler restarts, so the next advance comes a full prescale interval after that write.
- R3: A control write leaves `count` unchanged.
- R4: In free-running mode (control bits [1:0] = 0), the counter steps 0, 1, …, period and then returns to 0, which gives period+1 count ticks per cycle. The direction output stays 0.
- R5: In single-shot mode (mode 1), the counter runs one period. When it wraps to 0, the enable bit clears, so `running` falls, and the counter stays at 0.
- R6: In up/down modes (modes 2 and 3), the counter rises to the period value and holds it for one tick while `count_down` goes to 1. It then falls to 0 and holds 0 for one tick while `count_down` returns to 0. The full cycle is 2·(period+1) ticks.
- R7: In free-running and single-shot modes, a period written while running takes effect only when the counter wraps to 0.
- R8: In the up/down modes, a new period takes effect only on the tick where the falling counter turns at 0.
- R9: While the enable bit is 0, the active period follows the buffer, lagging it by one cycle, and the counter holds its value. Counter writes still apply.
- R10: The postscale field (control bits [7:4] = N) makes `event_pulse` high for one cycle on every (N+1)-th period match. No pulse appears before the (N+1)-th match.
- R11: Period matches occur only on prescaled ticks. Free-running and single-shot modes match at the wrap. Mode 2 matches at the top turn only. Mode 3 matches at both the top turn and the bottom turn.
- R12: After reset, `count`, `period`, `count_down`, `running` and `event_pulse` are all 0. A counter write also sets `count_down` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cnt | input | 1 | Write `wr_data[14:0]` to the counter |
| wr_ctl | input | 1 | Write the control word: [15] enable, [7:4] postscale, [3:2] prescale, [1:0] mode |
| wr_per | input | 1 | Write `wr_data[14:0]` to the period buffer |
| wr_data | input | 16 | Write data |
| count | output | 15 | Time base counter value |
| count_down | output | 1 | Direction flag, 1 while counting down |
| period | output | 15 | Active (working) period value |
| running | output | 1 | Enable bit of the control word |
| event_pulse | output | 1 | Postscaled period-match pulse |

## Verification
A vector table runs every mode against every prescale setting for a chosen number of cycles and checks the counter, direction and enable state. These checks separate a wrong prescale divide, a wrong wrap point, a missing dwell at the up/down turns, and a single-shot run that fails to stop. Directed sequences check the following:
- Control and counter writes placed part-way through a prescale interval, which shows whether the prescaler restarted and whether the counter survived.
- Period writes part-way through a count, which shows whether the reload waits for the correct instant in each mode.
- Pulse counts over fixed windows, which separate postscale divides and show the extra bottom-turn matches of mode 3.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    localparam int CNT_W  = 15;
    localparam int PRE_W  = 6;
    localparam int POST_W = 4;

    typedef enum logic [1:0] {
        TB_FREE    = 2'd0,
        TB_ONESHOT = 2'd1,
        TB_UPDN    = 2'd2,
        TB_UPDN2   = 2'd3
    } tb_mode_e;

    typedef struct packed {
        logic              en;
        logic [POST_W-1:0] post;
        logic [1:0]        pre;
        tb_mode_e          mode;
    } tb_ctl_t;

    function automatic tb_ctl_t unpack_ctl(input logic [15:0] w);
        tb_ctl_t c;
        c.en   = w[15];
        c.post = w[7:4];
        c.pre  = w[3:2];
        c.mode = tb_mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] s);
        return PRE_W'((1 << (2 * s)) - 1);
    endfunction

    function automatic logic is_updn(input tb_mode_e m);
        return (m == TB_UPDN) || (m == TB_UPDN2);
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_tb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] lim;

    assign lim  = pre_limit(sel);
    assign tick = run && !clr && (pre_cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pre_cnt <= '0;
        else if (run)
            pre_cnt <= (pre_cnt == lim) ? '0 : pre_cnt + 1'b1;
    end

    // R2: a clear leaves no tick in the next cycle unless the divide is 1
    a_r2_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clr && (sel != 2'd0) |=> !tick);
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  tb_mode_e         mode,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] per_buf,
    output logic [CNT_W-1:0] cnt,
    output logic             dir,
    output logic [CNT_W-1:0] per_act,
    output logic             match,
    output logic             oneshot_done
);
    logic at_top;
    logic at_bot;

    assign at_top = (cnt >= per_act);
    assign at_bot = (cnt == '0);

    always_comb begin
        match = 1'b0;
        if (tick && !ld_cnt) begin
            if (!is_updn(mode))
                match = at_top;
            else if (!dir)
                match = at_top;
            else
                match = (mode == TB_UPDN2) && at_bot;
        end
    end

    assign oneshot_done = match && (mode == TB_ONESHOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            dir     <= 1'b0;
            per_act <= '0;
        end else begin
            if (!run)
                per_act <= per_buf;
            if (ld_cnt) begin
                cnt <= cnt_val;
                dir <= 1'b0;
            end else if (tick) begin
                if (!is_updn(mode)) begin
                    dir <= 1'b0;
                    if (at_top) begin
                        cnt     <= '0;
                        per_act <= per_buf;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (!dir) begin
                    if (at_top) dir <= 1'b1;
                    else        cnt <= cnt + 1'b1;
                end else begin
                    if (at_bot) begin
                        dir     <= 1'b0;
                        per_act <= per_buf;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
        end
    end

    // R9: counter moves only on a tick or a load
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick && !ld_cnt |=> $stable(cnt));
    // R9: disabled time base copies the buffer
    a_r9_idle_reload: assert property (@(posedge clk) disable iff (rst)
        !run |=> per_act == $past(per_buf));
    // R6: the counter dwells on the turn tick
    a_r6_turn_dwell: assert property (@(posedge clk) disable iff (rst)
        $rose(dir) |-> cnt == $past(cnt));
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler
    import pwm_tb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              match,
    input  logic [POST_W-1:0] sel,
    output logic              evt
);
    logic [POST_W-1:0] post_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            post_cnt <= '0;
            evt      <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (match) begin
                if (post_cnt >= sel) begin
                    post_cnt <= '0;
                    evt      <= 1'b1;
                end else begin
                    post_cnt <= post_cnt + 1'b1;
                end
            end
        end
    end

    // R11: an event pulse is always caused by a match
    a_r11_evt_from_match: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(match));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cnt,
    input  logic             wr_ctl,
    input  logic             wr_per,
    input  logic [15:0]      wr_data,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic [CNT_W-1:0] period,
    output logic             running,
    output logic             event_pulse
);
    tb_ctl_t          ctl;
    logic [CNT_W-1:0] per_buf;
    logic             clr;
    logic             tick;
    logic             match;
    logic             oneshot_done;

    assign clr     = wr_cnt || wr_ctl;
    assign running = ctl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            per_buf <= '0;
        end else begin
            if (wr_ctl)
                ctl <= unpack_ctl(wr_data);
            else if (oneshot_done)
                ctl.en <= 1'b0;
            if (wr_per)
                per_buf <= wr_data[CNT_W-1:0];
        end
    end

    pwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .run  (ctl.en),
        .sel  (ctl.pre),
        .tick (tick)
    );

    pwm_count_core u_core (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .run          (ctl.en),
        .mode         (ctl.mode),
        .ld_cnt       (wr_cnt),
        .cnt_val      (wr_data[CNT_W-1:0]),
        .per_buf      (per_buf),
        .cnt          (count),
        .dir          (count_down),
        .per_act      (period),
        .match        (match),
        .oneshot_done (oneshot_done)
    );

    pwm_postscaler u_post (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .match (match),
        .sel   (ctl.post),
        .evt   (event_pulse)
    );

    // R3: control writes keep the counter
    a_r3_ctl_keeps_count: assert property (@(posedge clk) disable iff (rst)
        wr_ctl && !wr_cnt |=> count == $past(count));
    // R5: single-shot stop leaves the counter at zero
    a_r5_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
        $fell(running) && !$past(wr_ctl) |-> count == '0);
endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_cnt = 1'b0, wr_ctl = 1'b0, wr_per = 1'b0;
    logic [15:0] wr_data = '0;
    logic [14:0] count, period;
    logic        count_down, running, event_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwm_timebase u0 (
        .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wr_per(wr_per),
        .wr_data(wr_data), .count(count), .count_down(count_down),
        .period(period), .running(running), .event_pulse(event_pulse)
    );

    typedef struct packed {
        logic [15:0] ctl;
        logic [15:0] per;
        logic [15:0] n;
        logic [15:0] cnt;
        logic        dir;
        logic        en;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{16'h8000, 16'd9,   16'd5,   16'd5, 1'b0, 1'b1},  // R4
        '{16'h8000, 16'd9,   16'd12,  16'd2, 1'b0, 1'b1},  // R4
        '{16'h8004, 16'd9,   16'd13,  16'd3, 1'b0, 1'b1},  // R1
        '{16'h8008, 16'd3,   16'd100, 16'd2, 1'b0, 1'b1},  // R1
        '{16'h800C, 16'd100, 16'd200, 16'd3, 1'b0, 1'b1},  // R1
        '{16'h8002, 16'd4,   16'd6,   16'd3, 1'b1, 1'b1},  // R6
        '{16'h8002, 16'd4,   16'd10,  16'd0, 1'b0, 1'b1},  // R6
        '{16'h8002, 16'd4,   16'd11,  16'd1, 1'b0, 1'b1},  // R6
        '{16'h8003, 16'd4,   16'd7,   16'd2, 1'b1, 1'b1},  // R6
        '{16'h8006, 16'd4,   16'd26,  16'd3, 1'b1, 1'b1},  // R6 with R1
        '{16'h8001, 16'd3,   16'd3,   16'd3, 1'b0, 1'b1},  // R5
        '{16'h8001, 16'd3,   16'd4,   16'd0, 1'b0, 1'b0},  // R5
        '{16'h8001, 16'd3,   16'd20,  16'd0, 1'b0, 1'b0}   // R5
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input int kind, input logic [15:0] d);
        wr_data = d;
        wr_cnt  = (kind == 0);
        wr_ctl  = (kind == 1);
        wr_per  = (kind == 2);
        @(negedge clk);
        wr_cnt = 1'b0; wr_ctl = 1'b0; wr_per = 1'b0;
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] p);
        wr(1, 16'h0000);
        wr(2, p);
        wr(0, 16'h0000);
        wr(1, c);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pulses;
        int early;
        int back2back;
        logic prev;
        logic [14:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 count", count, 0);
        check("R12 period", period, 0);
        check("R12 dir", count_down, 0);
        check("R12 running", running, 0);
        check("R12 event", event_pulse, 0);

        for (int i = 0; i < NV; i++) begin
            setup(VEC[i].ctl, VEC[i].per);
            repeat (int'(VEC[i].n)) @(negedge clk);
            check($sformatf("R4/R5/R6 vec%0d count", i), count, int'(VEC[i].cnt));
            check($sformatf("R6 vec%0d dir", i), count_down, int'(VEC[i].dir));
            check($sformatf("R5 vec%0d running", i), running, int'(VEC[i].en));
        end

        // R2 and R3: control write mid-interval
        setup(16'h8004, 16'd100);
        repeat (10) @(negedge clk);
        wr(1, 16'h8004);
        check("R3 count kept", count, 2);
        repeat (3) @(negedge clk);
        check("R2 prescaler restarted by ctl", count, 2);
        @(negedge clk);
        check("R2 tick after full interval", count, 3);
        // R2: counter write mid-interval
        repeat (2) @(negedge clk);
        wr(0, 16'd50);
        repeat (3) @(negedge clk);
        check("R2 prescaler restarted by cnt", count, 50);
        @(negedge clk);
        check("R2 tick after cnt write", count, 51);

        // R10: postscale 1:3 over period 2 -> pulse every 9 cycles
        setup(16'h8020, 16'd2);
        pulses = 0; early = 0;
        for (int k = 1; k <= 45; k++) begin
            @(negedge clk);
            if (event_pulse) begin
                pulses++;
                if (k <= 8) early++;
            end
        end
        check("R10 no early pulse", early, 0);
        check("R10 pulse count", pulses, 5);

        // R11: matches only on prescaled ticks
        setup(16'h8004, 16'd0);
        pulses = 0; back2back = 0; prev = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (event_pulse) pulses++;
            if (event_pulse && prev) back2back++;
            prev = event_pulse;
        end
        check("R11 pulses on ticks", pulses, 10);
        check("R10 single-cycle pulse", back2back, 0);

        // R7: free-running reload at wrap
        setup(16'h8000, 16'd9);
        repeat (3) @(negedge clk);
        wr(2, 16'd4);
        check("R7 period held", period, 9);
        repeat (5) @(negedge clk);
        check("R7 period before wrap", period, 9);
        check("R7 count at top", count, 9);
        @(negedge clk);
        check("R7 period after wrap", period, 4);
        check("R7 count wrapped", count, 0);
        repeat (5) @(negedge clk);
        check("R7 new period used", count, 0);

        // R8: up/down reload at bottom turn
        setup(16'h8002, 16'd4);
        repeat (2) @(negedge clk);
        wr(2, 16'd2);
        repeat (6) @(negedge clk);
        check("R8 period before bottom turn", period, 4);
        check("R8 falling at zero", count_down, 1);
        @(negedge clk);
        check("R8 period after bottom turn", period, 2);
        repeat (3) @(negedge clk);
        check("R8 new top count", count, 2);
        check("R8 new top dir", count_down, 1);
        wr(0, 16'd0);
        check("R12 counter write sets up", count_down, 0);

        // R11: mode 3 matches at both turns
        setup(16'h8003, 16'd1);
        pulses = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (event_pulse) pulses++;
        end
        check("R11 dual-turn matches", pulses, 10);

        // R9: disabled behaviour
        wr(1, 16'h0000);
        @(negedge clk);
        wr(2, 16'd77);
        check("R9 one-cycle lag", period, 1);
        @(negedge clk);
        check("R9 idle reload", period, 77);
        held = count;
        repeat (10) @(negedge clk);
        check("R9 count held while off", count, int'(held));
        wr(0, 16'd123);
        check("R9 counter write while off", count, 123);

        finish_run();
    end
endmodule